// File: doc/BRIEF.md
# Loop-Indexed Address Generator with Buffer Renaming

This block produces SRAM addresses for array accesses inside a software-pipelined loop. Software loads a small set of address contexts. Each context picks two index sources. A source is either one of the loop unit's counters, the per-request unroll constant, or zero. For each source the context holds an offset to add and a shift to apply. It also holds a base address and a copy stride. On a request the selected context evaluates `base + ((i + off0) << sh0) + ((j + off1) << sh1)`. The registered result appears one cycle later.

The block also renames array variables. A rotating buffer tag steps on each iteration-issue pulse from the loop unit and wraps after the last copy. When a context has renaming enabled, the tag times the context's copy stride is added to its address. Successive overlapping iterations of one access therefore land in distinct copies of the buffer. A typical setup for a 16x16 matrix product uses row shift 4, matrix A at base 0 and matrix B at base 256. The B column access uses the constant source so that each unrolled copy adds its own offset (0 to 6).

A request to a context that was never written returns address 0 and raises an error flag.

Top module: `loop_addr_gen`

## Requirements
- R1: After reset, addrValid, addrErr, addrOut and addrTag are all 0, the buffer tag is 0, and no context counts as configured.
- R2: A request accepted at a clock edge gives addrValid high during exactly the following cycle. A cycle with no request gives addrValid low in the next cycle.
- R3: For a configured context the address is (base + ((i + off0) << sh0) + ((j + off1) << sh1) + renameTerm) modulo 2^ADDR_W. i and j are the values of source 0 and source 1.
- R4: Source select codes are as follows. Code l, for l below NUM_LOOPS, takes loop counter l from loopIdx bits [l*IDX_W +: IDX_W]. Code NUM_LOOPS takes the request's reqUnroll value. Any higher code gives zero. With the defaults: 0 = counter 0, 1 = counter 1, 2 = unroll constant, 3 = zero.
- R5: A request to a context that has never been written gives addrOut = 0 and addrErr = 1 in its result cycle. A configured context gives addrErr = 0.
- R6: The buffer tag steps by one on each iterPulse and wraps from NUM_COPIES-1 to 0. It holds when there is no pulse. addrTag reports the tag used for the result.
- R7: With a context's rename bit set, renameTerm is tag * stride. With the bit clear, renameTerm is 0 for any tag.
- R8: A configuration write or an iterPulse in the same cycle as a request affects only later requests. That request sees the context and tag as they were before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write all fields of context cfgCtx |
| cfgCtx | input | CTX_W | Context being written |
| cfgSel0 | input | SEL_W | Source code for index i |
| cfgSel1 | input | SEL_W | Source code for index j |
| cfgOff0 | input | IDX_W | Offset added to i |
| cfgOff1 | input | IDX_W | Offset added to j |
| cfgShift0 | input | SHIFT_W | Left shift applied to (i + off0) |
| cfgShift1 | input | SHIFT_W | Left shift applied to (j + off1) |
| cfgBase | input | ADDR_W | Base address including constant terms |
| cfgStride | input | ADDR_W | Distance between buffer copies |
| cfgRename | input | 1 | Enable tag-based renaming for the context |
| loopIdx | input | NUM_LOOPS*IDX_W | Current loop counter values, counter l at [l*IDX_W +: IDX_W] |
| iterPulse | input | 1 | New iteration issued; advances the tag |
| reqValid | input | 1 | Address request |
| reqCtx | input | CTX_W | Context used by the request |
| reqUnroll | input | IDX_W | Unroll constant for the constant source |
| addrValid | output | 1 | Result valid, one cycle after request |
| addrOut | output | ADDR_W | Computed address |
| addrErr | output | 1 | Request hit an unconfigured context |
| addrTag | output | TAG_W | Buffer tag used for this result |

## Verification
A wrong tag count shows up at the next request from a renaming context, as an address off by a multiple of the stride and an addrTag that disagrees with the pulse count. A stuck or lost configured bit shows up in the very next result cycle, as a false addrErr or a missing one. Source-select or shift faults show up as soon as a sweep moves the affected counter. The full sweep of both counters and of the unroll constant lets a single wrong select code or shift appear within a few requests. Every result arrives one cycle after its request, so each fault is seen no later than that cycle.

// File: rtl/lag_pkg.sv
package lag_pkg;
  // Strobes from control to datapath for one request cycle
  typedef struct packed {
    logic capture;  // a request is being accepted
    logic fault;    // that request targets an unconfigured context
  } agStrobe_t;
endpackage

// File: rtl/lag_control.sv
module lag_control
  import lag_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter int NUM_COPIES = 4,
  parameter int CTX_W      = 2,
  parameter int TAG_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CTX_W-1:0] cfgCtx,
  input  logic             reqValid,
  input  logic [CTX_W-1:0] reqCtx,
  input  logic             iterPulse,
  output agStrobe_t        strobe,
  output logic [TAG_W-1:0] tag
);
  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NUM_COPIES - 1);

  logic [NUM_CTX-1:0] configured;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      configured <= '0;
      tag        <= '0;
    end else begin
      if (cfgWe) configured[cfgCtx] <= 1'b1;
      if (iterPulse) tag <= (tag == LAST_TAG) ? '0 : tag + 1'b1;
    end
  end

  always_comb begin
    strobe.capture = reqValid;
    strobe.fault   = reqValid && !configured[reqCtx];
  end

  // R6: tag never leaves the copy range
  a_r6_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tag) < NUM_COPIES);
  // R6: tag holds without an iteration pulse
  a_r6_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !iterPulse |=> $stable(tag));
  // R6: wrap from the last copy to zero
  a_r6_tag_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (iterPulse && tag == LAST_TAG) |=> tag == '0);
endmodule

// File: rtl/lag_datapath.sv
module lag_datapath
  import lag_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int NUM_LOOPS = 2,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 10,
  parameter int SHIFT_W   = 3,
  parameter int CTX_W     = 2,
  parameter int SEL_W     = 2,
  parameter int TAG_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWe,
  input  logic [CTX_W-1:0]           cfgCtx,
  input  logic [SEL_W-1:0]           cfgSel0,
  input  logic [SEL_W-1:0]           cfgSel1,
  input  logic [IDX_W-1:0]           cfgOff0,
  input  logic [IDX_W-1:0]           cfgOff1,
  input  logic [SHIFT_W-1:0]         cfgShift0,
  input  logic [SHIFT_W-1:0]         cfgShift1,
  input  logic [ADDR_W-1:0]          cfgBase,
  input  logic [ADDR_W-1:0]          cfgStride,
  input  logic                       cfgRename,
  input  logic [NUM_LOOPS*IDX_W-1:0] loopIdx,
  input  logic [CTX_W-1:0]           reqCtx,
  input  logic [IDX_W-1:0]           reqUnroll,
  input  agStrobe_t                  strobe,
  input  logic [TAG_W-1:0]           tag,
  output logic                       addrValid,
  output logic [ADDR_W-1:0]          addrOut,
  output logic                       addrErr,
  output logic [TAG_W-1:0]           addrTag
);
  localparam int NUM_TERMS = 2;
  localparam logic [SEL_W-1:0] SEL_CONST = SEL_W'(NUM_LOOPS);

  logic [SEL_W-1:0]   selR   [NUM_CTX][NUM_TERMS];
  logic [IDX_W-1:0]   offR   [NUM_CTX][NUM_TERMS];
  logic [SHIFT_W-1:0] shiftR [NUM_CTX][NUM_TERMS];
  logic [ADDR_W-1:0]  baseR  [NUM_CTX];
  logic [ADDR_W-1:0]  strideR[NUM_CTX];
  logic               renameR[NUM_CTX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        for (int t = 0; t < NUM_TERMS; t++) begin
          selR[c][t]   <= '0;
          offR[c][t]   <= '0;
          shiftR[c][t] <= '0;
        end
        baseR[c]   <= '0;
        strideR[c] <= '0;
        renameR[c] <= 1'b0;
      end
    end else if (cfgWe) begin
      selR[cfgCtx][0]   <= cfgSel0;
      selR[cfgCtx][1]   <= cfgSel1;
      offR[cfgCtx][0]   <= cfgOff0;
      offR[cfgCtx][1]   <= cfgOff1;
      shiftR[cfgCtx][0] <= cfgShift0;
      shiftR[cfgCtx][1] <= cfgShift1;
      baseR[cfgCtx]     <= cfgBase;
      strideR[cfgCtx]   <= cfgStride;
      renameR[cfgCtx]   <= cfgRename;
    end
  end

  // One shift-add lane per index source
  logic [ADDR_W-1:0] termVal[NUM_TERMS];

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [IDX_W-1:0] idxVal;
    always_comb begin
      idxVal = '0;
      for (int l = 0; l < NUM_LOOPS; l++)
        if (selR[reqCtx][t] == SEL_W'(l)) idxVal = loopIdx[l*IDX_W +: IDX_W];
      if (selR[reqCtx][t] == SEL_CONST) idxVal = reqUnroll;
      termVal[t] = (ADDR_W'(idxVal) + ADDR_W'(offR[reqCtx][t])) << shiftR[reqCtx][t];
    end
  end

  logic [ADDR_W-1:0] renameOff;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    renameOff = renameR[reqCtx] ? ADDR_W'(tag) * strideR[reqCtx] : '0;
    addrNext  = baseR[reqCtx] + termVal[0] + termVal[1] + renameOff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
      addrErr   <= 1'b0;
      addrTag   <= '0;
    end else begin
      addrValid <= strobe.capture;
      addrErr   <= strobe.fault;
      if (strobe.capture) begin
        addrOut <= strobe.fault ? '0 : addrNext;
        addrTag <= tag;
      end
    end
  end

  // R5: an error result always carries address zero
  a_r5_err_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addrErr |-> (addrValid && addrOut == '0));
endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
  import lag_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter int NUM_LOOPS  = 2,
  parameter int NUM_COPIES = 4,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 10,
  parameter int SHIFT_W    = 3,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int SEL_W     = $clog2(NUM_LOOPS + 2),
  localparam int TAG_W     = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWe,
  input  logic [CTX_W-1:0]           cfgCtx,
  input  logic [SEL_W-1:0]           cfgSel0,
  input  logic [SEL_W-1:0]           cfgSel1,
  input  logic [IDX_W-1:0]           cfgOff0,
  input  logic [IDX_W-1:0]           cfgOff1,
  input  logic [SHIFT_W-1:0]         cfgShift0,
  input  logic [SHIFT_W-1:0]         cfgShift1,
  input  logic [ADDR_W-1:0]          cfgBase,
  input  logic [ADDR_W-1:0]          cfgStride,
  input  logic                       cfgRename,
  input  logic [NUM_LOOPS*IDX_W-1:0] loopIdx,
  input  logic                       iterPulse,
  input  logic                       reqValid,
  input  logic [CTX_W-1:0]           reqCtx,
  input  logic [IDX_W-1:0]           reqUnroll,
  output logic                       addrValid,
  output logic [ADDR_W-1:0]          addrOut,
  output logic                       addrErr,
  output logic [TAG_W-1:0]           addrTag
);
  agStrobe_t        strobe;
  logic [TAG_W-1:0] tag;

  lag_control #(
    .NUM_CTX(NUM_CTX), .NUM_COPIES(NUM_COPIES), .CTX_W(CTX_W), .TAG_W(TAG_W)
  ) u_control (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgCtx(cfgCtx),
    .reqValid(reqValid), .reqCtx(reqCtx), .iterPulse(iterPulse),
    .strobe(strobe), .tag(tag)
  );

  lag_datapath #(
    .NUM_CTX(NUM_CTX), .NUM_LOOPS(NUM_LOOPS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .SHIFT_W(SHIFT_W), .CTX_W(CTX_W), .SEL_W(SEL_W), .TAG_W(TAG_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgCtx(cfgCtx),
    .cfgSel0(cfgSel0), .cfgSel1(cfgSel1), .cfgOff0(cfgOff0), .cfgOff1(cfgOff1),
    .cfgShift0(cfgShift0), .cfgShift1(cfgShift1), .cfgBase(cfgBase),
    .cfgStride(cfgStride), .cfgRename(cfgRename), .loopIdx(loopIdx),
    .reqCtx(reqCtx), .reqUnroll(reqUnroll), .strobe(strobe), .tag(tag),
    .addrValid(addrValid), .addrOut(addrOut), .addrErr(addrErr), .addrTag(addrTag)
  );

  // R2: one result cycle per request, none without
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> addrValid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !addrValid);
  // R8: the reported tag is the one present before the request edge
  a_r8_tag_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> addrTag == $past(tag));
endmodule

// File: tb/loop_addr_gen_bench.sv
module loop_addr_gen_bench;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       cfgWe = 0;
  logic [1:0] cfgCtx = 0, cfgSel0 = 0, cfgSel1 = 0;
  logic [3:0] cfgOff0 = 0, cfgOff1 = 0;
  logic [2:0] cfgShift0 = 0, cfgShift1 = 0;
  logic [AW-1:0] cfgBase = 0, cfgStride = 0;
  logic       cfgRename = 0;
  logic [7:0] loopIdx = 0;
  logic       iterPulse = 0, reqValid = 0;
  logic [1:0] reqCtx = 0;
  logic [3:0] reqUnroll = 0;
  logic          addrValid, addrErr;
  logic [AW-1:0] addrOut;
  logic [1:0]    addrTag;

  loop_addr_gen u_loop_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgCtx(cfgCtx),
    .cfgSel0(cfgSel0), .cfgSel1(cfgSel1), .cfgOff0(cfgOff0), .cfgOff1(cfgOff1),
    .cfgShift0(cfgShift0), .cfgShift1(cfgShift1), .cfgBase(cfgBase),
    .cfgStride(cfgStride), .cfgRename(cfgRename), .loopIdx(loopIdx),
    .iterPulse(iterPulse), .reqValid(reqValid), .reqCtx(reqCtx),
    .reqUnroll(reqUnroll), .addrValid(addrValid), .addrOut(addrOut),
    .addrErr(addrErr), .addrTag(addrTag)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench-side model of the configuration (from the requirements)
  logic [1:0]    mSel0[4], mSel1[4];
  logic [3:0]    mOff0[4], mOff1[4];
  logic [2:0]    mSh0[4], mSh1[4];
  logic [AW-1:0] mBase[4], mStride[4];
  logic          mRen[4], mCfg[4];
  int            mTag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] pick(input logic [1:0] s, input logic [3:0] l0,
                                         input logic [3:0] l1, input logic [3:0] u);
    case (s)
      2'd0: pick = AW'(l0);
      2'd1: pick = AW'(l1);
      2'd2: pick = AW'(u);
      default: pick = '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] model(input int c, input logic [3:0] l0,
                                          input logic [3:0] l1, input logic [3:0] u);
    logic [AW-1:0] a;
    a = mBase[c] + ((pick(mSel0[c], l0, l1, u) + AW'(mOff0[c])) << mSh0[c])
                 + ((pick(mSel1[c], l0, l1, u) + AW'(mOff1[c])) << mSh1[c]);
    if (mRen[c]) a = a + AW'(mTag) * mStride[c];
    return a;
  endfunction

  task automatic setCfg(input int c, input logic [1:0] s0, input logic [1:0] s1,
                        input logic [3:0] o0, input logic [3:0] o1,
                        input logic [2:0] h0, input logic [2:0] h1,
                        input logic [AW-1:0] b, input logic [AW-1:0] st, input bit ren);
    cfgWe = 1; cfgCtx = 2'(c); cfgSel0 = s0; cfgSel1 = s1; cfgOff0 = o0; cfgOff1 = o1;
    cfgShift0 = h0; cfgShift1 = h1; cfgBase = b; cfgStride = st; cfgRename = ren;
    @(negedge clk);
    cfgWe = 0;
    mSel0[c] = s0; mSel1[c] = s1; mOff0[c] = o0; mOff1[c] = o1;
    mSh0[c] = h0; mSh1[c] = h1; mBase[c] = b; mStride[c] = st; mRen[c] = ren; mCfg[c] = 1;
  endtask

  // Issue one request (optionally with a pulse) and check its result next cycle
  task automatic doReq(input int c, input logic [3:0] l0, input logic [3:0] l1,
                       input logic [3:0] u, input bit pulse, input string req);
    logic [AW-1:0] exp;
    int expTag;
    exp = mCfg[c] ? model(c, l0, l1, u) : '0;
    expTag = mTag;
    reqValid = 1; reqCtx = 2'(c); loopIdx = {l1, l0}; reqUnroll = u; iterPulse = pulse;
    @(negedge clk);
    reqValid = 0; iterPulse = 0;
    if (pulse) mTag = (mTag + 1) % 4;
    check(addrValid == 1'b1, {req, " valid (R2)"}, int'(addrValid), 1);
    check(addrOut == exp, req, int'(addrOut), int'(exp));
    check(addrErr == !mCfg[c], {req, " err (R5)"}, int'(addrErr), int'(!mCfg[c]));
    check(int'(addrTag) == expTag, {req, " tag (R6)"}, int'(addrTag), expTag);
  endtask

  task automatic pulseOnly();
    iterPulse = 1;
    @(negedge clk);
    iterPulse = 0;
    mTag = (mTag + 1) % 4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      mCfg[c] = 0; mRen[c] = 0; mSel0[c] = 0; mSel1[c] = 0; mOff0[c] = 0; mOff1[c] = 0;
      mSh0[c] = 0; mSh1[c] = 0; mBase[c] = 0; mStride[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(addrValid == 0, "R1 valid", int'(addrValid), 0);
    check(addrErr == 0, "R1 err", int'(addrErr), 0);
    check(addrOut == 0, "R1 addr", int'(addrOut), 0);
    check(addrTag == 0, "R1 tag", int'(addrTag), 0);
    // R1/R5: nothing configured after reset
    for (int c = 0; c < 4; c++) doReq(c, 4'd3, 4'd5, 4'd1, 0, "R1 unconfigured");

    // R3/R4: matrix A row access, base 0, shift 4 on counter 0 plus counter 1
    setCfg(0, 2'd0, 2'd1, 4'd0, 4'd0, 3'd4, 3'd0, 10'd0, 10'd0, 0);
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < 16; k++) doReq(0, 4'(r), 4'(k), 4'd0, 0, "R3 A sweep");

    // R4: matrix B column access, counter 1 shifted, unroll constant, base 256
    setCfg(1, 2'd1, 2'd2, 4'd0, 4'd0, 3'd4, 3'd0, 10'd256, 10'd0, 0);
    for (int k = 0; k < 16; k++)
      for (int u = 0; u < 7; u++) doReq(1, 4'd9, 4'(k), 4'(u), 0, "R4 B sweep");

    // R3: offsets, both shifts, zero source, and wrap modulo 2^ADDR_W
    setCfg(2, 2'd3, 2'd0, 4'd7, 4'd3, 3'd5, 3'd6, 10'd1000, 10'd0, 0);
    for (int r = 0; r < 16; r++) doReq(2, 4'(r), 4'd2, 4'd4, 0, "R3 offsets wrap");

    // R2: no request gives no result cycle
    @(negedge clk);
    check(addrValid == 0, "R2 idle", int'(addrValid), 1'b0);

    // R6/R7: renaming with stride 64 over several wraps
    setCfg(2, 2'd3, 2'd0, 4'd0, 4'd0, 3'd0, 3'd1, 10'd5, 10'd64, 1);
    for (int it = 0; it < 10; it++) begin
      doReq(2, 4'(it), 4'd0, 4'd0, 0, "R7 rename");
      pulseOnly();
    end
    // R7: rename bit clear ignores tag, with tag non-zero
    pulseOnly();
    check(mTag != 0, "R7 precondition tag", mTag, 1);
    for (int r = 0; r < 4; r++) doReq(0, 4'(r), 4'(r), 4'd0, 0, "R7 no rename");

    // R8: pulse in same cycle as request uses old tag; next request sees new tag
    for (int it = 0; it < 6; it++) doReq(2, 4'd1, 4'd0, 4'd0, 1, "R8 pulse same cycle");

    // R8: write and request to unconfigured context 3 in the same cycle
    cfgWe = 1; cfgCtx = 2'd3; cfgSel0 = 2'd0; cfgSel1 = 2'd3; cfgOff0 = 4'd1; cfgOff1 = 4'd0;
    cfgShift0 = 3'd2; cfgShift1 = 3'd0; cfgBase = 10'd100; cfgStride = 10'd0; cfgRename = 0;
    reqValid = 1; reqCtx = 2'd3; loopIdx = 8'h02;
    @(negedge clk);
    cfgWe = 0; reqValid = 0;
    check(addrErr == 1, "R8 old config err", int'(addrErr), 1);
    check(addrOut == 0, "R8 old config addr", int'(addrOut), 0);
    mSel0[3] = 2'd0; mSel1[3] = 2'd3; mOff0[3] = 4'd1; mOff1[3] = 4'd0; mSh0[3] = 3'd2;
    mSh1[3] = 3'd0; mBase[3] = 10'd100; mStride[3] = 0; mRen[3] = 0; mCfg[3] = 1;
    for (int r = 0; r < 16; r++) doReq(3, 4'(r), 4'd7, 4'd0, 0, "R8 new config");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule